// File: doc/BRIEF.md
# Distributed Rotating-ID Bus Arbiter

This block is the arbitration logic held by every symmetric agent on a shared bus with up to four such agents. Each agent carries an identical copy. All copies watch the same active-low request lines, so they reach the same ownership decision without any central arbiter. Each copy keeps a record of the most recent symmetric owner (the rotating ID) and a two-valued ownership state, idle or busy. From these it works out who owns the bus next in round-robin order.

An owner may run one transaction. After that it must give way to any other requester, unless the transaction is locked. If nobody else is asking, ownership stays with the last owner. Three more inputs shape the decision. A lock input and a priority-agent request both freeze symmetric ownership. A block-next-request input holds off new transaction issue. The only per-copy difference is the agent number strap, which selects the copy's own view of whether it owns the bus and may issue.

Top module: `rid_bus_arbiter`

## Requirements
- R1: After reset the rotating ID is N-1 (3 for four agents), the state is idle, and no copy reports ownership or permission to issue.
- R2: Request bit i (breq_n_i[i] low = agent i requests) is registered on one clock edge. The winner is resolved from that registered value, and the ownership outputs change on the following edge, two edges after the request is driven.
- R3: The winner is the first requesting agent found by counting upward from the rotating ID plus one, wrapping modulo N. With ID 3 the order is 0, 1, 2, 3.
- R4: The rotating ID only ever takes the number of an agent whose registered request was active. The first grant from idle sets the state to busy.
- R5: Once the state is busy it stays busy. When the owner drops its request and no other agent requests, the rotating ID keeps the owner's number.
- R6: An owner that has issued one transaction (address strobe ads_n_i low, seen while busy and not locked) hands over to the next requester as soon as any other agent requests, even if it still requests.
- R7: An owner that drops its request hands over at once to the next requester. The released agent can request again in the very next clock and is then ranked like any other agent.
- R8: While the registered lock input (lock_n_i low) or priority-agent request (prio_req_n_i low) is active, the rotating ID and state do not change. An address strobe seen under lock does not count as the owner's one transaction.
- R9: issue_ok_o is high only when the copy's agent is the busy owner, has not yet used its transaction, and neither the registered block-next-request (block_n_i low) nor the priority-agent request is active.
- R10: All copies fed the same inputs report the same owner_o and busy_o. owner_self_o is high in exactly the copy whose agent_id_i equals owner_o while busy, and in none while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| agent_id_i | input | ID_W | Agent number strap of this copy |
| breq_n_i | input | N_AGENTS | Symmetric request lines, active low, bit i for agent i |
| ads_n_i | input | 1 | Transaction-start (address) strobe, active low |
| lock_n_i | input | 1 | Locked-operation input, active low |
| prio_req_n_i | input | 1 | Priority-agent request, active low |
| block_n_i | input | 1 | Block-next-request, active low |
| owner_o | output | ID_W | Current rotating ID (last or present symmetric owner) |
| busy_o | output | 1 | Ownership state: 1 busy, 0 idle |
| owner_self_o | output | 1 | This copy's agent is the symmetric owner |
| issue_ok_o | output | 1 | This copy's agent may start a transaction now |

## Verification
The delicate overlap is an address strobe arriving in the same cycle as the lock input or the priority-agent request. The one-transaction flag and the ownership freeze then compete for the same state update. The bench drives the strobe together with lock and, separately, together with the priority request, while every agent keeps requesting. After lock is dropped the owner must still be in place, because a locked strobe does not use up its transaction. After the priority request is dropped, ownership must pass to the next agent exactly two edges later. Random request traffic then checks that the four copies agree in every cycle and that each change of owner follows the wrap-around order.

// File: rtl/rid_arb_pkg.sv
package rid_arb_pkg;
  localparam int unsigned ARB_AGENTS = 4;

  typedef enum logic {
    OWN_IDLE = 1'b0,
    OWN_BUSY = 1'b1
  } own_state_e;
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/arb_in_sampler.sv
module arb_in_sampler #(
  parameter int unsigned N_AGENTS = rid_arb_pkg::ARB_AGENTS
) (
  input  logic                clk,
  input  logic                rst_sn,
  input  logic [N_AGENTS-1:0] breq_n_i,
  input  logic                ads_n_i,
  input  logic                lock_n_i,
  input  logic                prio_n_i,
  input  logic                blk_n_i,
  output logic [N_AGENTS-1:0] req_s_o,
  output logic                ads_s_o,
  output logic                lock_s_o,
  output logic                prio_s_o,
  output logic                blk_s_o
);
  // registered, active-high copies of the shared bus lines
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      req_s_o  <= '0;
      ads_s_o  <= 1'b0;
      lock_s_o <= 1'b0;
      prio_s_o <= 1'b0;
      blk_s_o  <= 1'b0;
    end else begin
      req_s_o  <= ~breq_n_i;
      ads_s_o  <= ~ads_n_i;
      lock_s_o <= ~lock_n_i;
      prio_s_o <= ~prio_n_i;
      blk_s_o  <= ~blk_n_i;
    end
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned N_AGENTS = rid_arb_pkg::ARB_AGENTS,
  parameter int unsigned ID_W     = $clog2(N_AGENTS)
) (
  input  logic [ID_W-1:0]     last_i,
  input  logic [N_AGENTS-1:0] req_i,
  output logic [ID_W-1:0]     pick_o,
  output logic                any_o
);
  // scan from the farthest offset down so the nearest requester wins
  always_comb begin
    int idx;
    pick_o = last_i;
    any_o  = |req_i;
    for (int k = N_AGENTS; k >= 1; k--) begin
      idx = (int'(last_i) + k) % int'(N_AGENTS);
      if (req_i[idx]) pick_o = ID_W'(idx);
    end
  end
endmodule

// File: rtl/arb_own_state.sv
module arb_own_state
  import rid_arb_pkg::*;
#(
  parameter int unsigned N_AGENTS = rid_arb_pkg::ARB_AGENTS,
  parameter int unsigned ID_W     = $clog2(N_AGENTS)
) (
  input  logic                clk,
  input  logic                rst_sn,
  input  logic [N_AGENTS-1:0] req_s_i,
  input  logic                ads_s_i,
  input  logic                lock_s_i,
  input  logic                prio_s_i,
  input  logic [ID_W-1:0]     pick_i,
  input  logic                any_i,
  output logic [ID_W-1:0]     rid_q,
  output own_state_e          state_q,
  output logic                done_q
);
  localparam logic [ID_W-1:0] RID_RST = ID_W'(N_AGENTS - 1);

  logic [ID_W-1:0]     rid_n;
  own_state_e          state_n;
  logic                done_n;
  logic [N_AGENTS-1:0] own_mask;
  logic                own_req, others, hold, handoff;

  always_comb begin
    own_mask        = '0;
    own_mask[rid_q] = 1'b1;
  end

  assign own_req = req_s_i[rid_q];
  assign others  = |(req_s_i & ~own_mask);
  assign hold    = lock_s_i | prio_s_i;

  always_comb begin
    rid_n   = rid_q;
    state_n = state_q;
    done_n  = done_q;
    handoff = 1'b0;
    if (state_q == OWN_IDLE) begin
      done_n = 1'b0;
      if (!hold && any_i) begin
        rid_n   = pick_i;
        state_n = OWN_BUSY;
      end
    end else begin
      handoff = !hold && others && (!own_req || done_q);
      if (handoff) begin
        rid_n  = pick_i;
        done_n = 1'b0;
      end else if (ads_s_i && !lock_s_i) begin
        done_n = 1'b1;
      end else if (!others) begin
        done_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rid_q   <= RID_RST;
      state_q <= OWN_IDLE;
      done_q  <= 1'b0;
    end else begin
      rid_q   <= rid_n;
      state_q <= state_n;
      done_q  <= done_n;
    end
  end

  assert_pick_requested_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    any_i |-> req_s_i[pick_i]);

  assert_owner_was_requester_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (rid_n != rid_q) |-> req_s_i[rid_n]);

  assert_busy_sticky_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == OWN_BUSY) |=> (state_q == OWN_BUSY));

  assert_hold_freezes_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (lock_s_i || prio_s_i) |=> ($stable(rid_q) && $stable(state_q)));
endmodule

// File: rtl/rid_bus_arbiter.sv
module rid_bus_arbiter
  import rid_arb_pkg::*;
#(
  parameter int unsigned N_AGENTS = rid_arb_pkg::ARB_AGENTS,
  parameter int unsigned ID_W     = $clog2(N_AGENTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ID_W-1:0]     agent_id_i,
  input  logic [N_AGENTS-1:0] breq_n_i,
  input  logic                ads_n_i,
  input  logic                lock_n_i,
  input  logic                prio_req_n_i,
  input  logic                block_n_i,
  output logic [ID_W-1:0]     owner_o,
  output logic                busy_o,
  output logic                owner_self_o,
  output logic                issue_ok_o
);
  logic                rst_sn;
  logic [N_AGENTS-1:0] req_s;
  logic                ads_s, lock_s, prio_s, blk_s;
  logic [ID_W-1:0]     rid_q, pick;
  logic                any_req, done_q;
  own_state_e          state_q;

  arb_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  arb_in_sampler #(.N_AGENTS(N_AGENTS)) u_sampler (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .breq_n_i (breq_n_i),
    .ads_n_i  (ads_n_i),
    .lock_n_i (lock_n_i),
    .prio_n_i (prio_req_n_i),
    .blk_n_i  (block_n_i),
    .req_s_o  (req_s),
    .ads_s_o  (ads_s),
    .lock_s_o (lock_s),
    .prio_s_o (prio_s),
    .blk_s_o  (blk_s)
  );

  arb_rr_pick #(.N_AGENTS(N_AGENTS), .ID_W(ID_W)) u_pick (
    .last_i (rid_q),
    .req_i  (req_s),
    .pick_o (pick),
    .any_o  (any_req)
  );

  arb_own_state #(.N_AGENTS(N_AGENTS), .ID_W(ID_W)) u_state (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .req_s_i  (req_s),
    .ads_s_i  (ads_s),
    .lock_s_i (lock_s),
    .prio_s_i (prio_s),
    .pick_i   (pick),
    .any_i    (any_req),
    .rid_q    (rid_q),
    .state_q  (state_q),
    .done_q   (done_q)
  );

  assign owner_o      = rid_q;
  assign busy_o       = (state_q == OWN_BUSY);
  assign owner_self_o = busy_o && (rid_q == agent_id_i);
  assign issue_ok_o   = owner_self_o && !done_q && !blk_s && !prio_s;

  assert_block_stalls_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (blk_s || prio_s) |-> !issue_ok_o);

  assert_issue_needs_owner_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    issue_ok_o |-> (owner_self_o && busy_o));
endmodule

// File: tb/rid_bus_arbiter_bench.sv
module rid_bus_arbiter_bench;
  localparam int NA = 4;

  logic          clk;
  logic          rst_n;
  logic [NA-1:0] breq_n;
  logic          ads_n, lock_n, prio_n, blk_n;
  logic [1:0]    own [NA];
  logic [NA-1:0] busyv, selfv, iokv;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  for (genvar i = 0; i < NA; i++) begin : g_copy
    rid_bus_arbiter u_rid_bus_arbiter (
      .clk          (clk),
      .rst_n        (rst_n),
      .agent_id_i   (2'(i)),
      .breq_n_i     (breq_n),
      .ads_n_i      (ads_n),
      .lock_n_i     (lock_n),
      .prio_req_n_i (prio_n),
      .block_n_i    (blk_n),
      .owner_o      (own[i]),
      .busy_o       (busyv[i]),
      .owner_self_o (selfv[i]),
      .issue_ok_o   (iokv[i])
    );
  end

  // {breq_n, ads pulse, expected rid, expected busy}
  localparam logic [7:0] VEC [16] = '{
    {4'b1111, 1'b0, 2'd3, 1'b0},
    {4'b1100, 1'b0, 2'd0, 1'b1},
    {4'b1100, 1'b1, 2'd0, 1'b1},
    {4'b1100, 1'b0, 2'd1, 1'b1},
    {4'b1110, 1'b0, 2'd0, 1'b1},
    {4'b1111, 1'b0, 2'd0, 1'b1},
    {4'b0111, 1'b0, 2'd3, 1'b1},
    {4'b0101, 1'b0, 2'd3, 1'b1},
    {4'b0101, 1'b1, 2'd3, 1'b1},
    {4'b0101, 1'b0, 2'd1, 1'b1},
    {4'b1011, 1'b0, 2'd2, 1'b1},
    {4'b0000, 1'b0, 2'd2, 1'b1},
    {4'b0000, 1'b1, 2'd2, 1'b1},
    {4'b0000, 1'b0, 2'd3, 1'b1},
    {4'b0000, 1'b1, 2'd3, 1'b1},
    {4'b0000, 1'b0, 2'd0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R10: every copy shows the same owner and exactly the matching self flag
  task automatic chk_agree(input string req);
    logic [NA-1:0] exp_self;
    bit same;
    same = 1'b1;
    for (int i = 1; i < NA; i++)
      if (own[i] !== own[0] || busyv[i] !== busyv[0]) same = 1'b0;
    exp_self = busyv[0] ? (NA'(1) << own[0]) : '0;
    chk(same && (selfv === exp_self), req, int'(selfv), int'(exp_self));
  endtask

  task automatic chk_state(input string req, input int rid, input bit busy);
    chk(own[0] === 2'(rid), req, int'(own[0]), rid);
    chk(busyv[0] === busy, req, int'(busyv[0]), int'(busy));
    chk_agree({req, "/R10"});
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NA-1:0] d1, d2, req;
    logic [1:0]    prev;
    int            exp_pick;

    rst_n = 1'b0; breq_n = '1; ads_n = 1'b1; lock_n = 1'b1; prio_n = 1'b1; blk_n = 1'b1;
    step(3);
    // R1: state while reset is applied
    chk_state("R1 reset", 3, 1'b0);
    chk(iokv === '0, "R1 issue", int'(iokv), 0);
    rst_n = 1'b1;
    step(4);
    chk_state("R1 after release", 3, 1'b0);

    // table walk: each row held two edges, strobe only in the first
    for (int v = 0; v < 16; v++) begin
      breq_n = VEC[v][7:4];
      ads_n  = ~VEC[v][3];
      @(posedge clk);
      @(negedge clk);
      ads_n = 1'b1;
      if (v == 1) chk_state("R2 one edge, still idle", 3, 1'b0);
      @(posedge clk);
      @(negedge clk);
      chk_state($sformatf("R3 R6 R7 row %0d", v), int'(VEC[v][2:1]), VEC[v][0]);
    end

    // R8: strobe under lock does not use up the transaction
    lock_n = 1'b0; ads_n = 1'b0;
    step(1);
    ads_n = 1'b1;
    step(3);
    chk_state("R8 lock holds owner", 0, 1'b1);
    lock_n = 1'b1;
    step(3);
    chk_state("R8 locked strobe ignored", 0, 1'b1);

    // R8: strobe together with priority request, owner frozen
    ads_n = 1'b0; prio_n = 1'b0;
    step(1);
    ads_n = 1'b1;
    step(3);
    chk_state("R8 priority freezes", 0, 1'b1);
    chk(iokv[0] === 1'b0, "R9 priority stalls issue", int'(iokv[0]), 0);
    prio_n = 1'b1;
    step(1);
    chk_state("R8 release plus one", 0, 1'b1);
    step(1);
    chk_state("R6 hand over after priority", 1, 1'b1);

    // R9: block-next stalls issue permission
    chk(iokv === 4'b0010, "R9 issue before block", int'(iokv), 2);
    blk_n = 1'b0;
    step(2);
    chk(iokv === 4'b0000, "R9 block stalls", int'(iokv), 0);
    chk_state("R9 block keeps owner", 1, 1'b1);
    blk_n = 1'b1;
    step(2);
    chk(iokv === 4'b0010, "R9 issue restored", int'(iokv), 2);

    // R7: release then immediate re-request by the released agent
    breq_n = 4'b1110;
    step(2);
    chk_state("R7 drop hands to agent 0", 0, 1'b1);
    breq_n = 4'b1100;
    step(2);
    chk_state("R7 agent 1 back, owner keeps", 0, 1'b1);
    ads_n = 1'b0;
    step(1);
    ads_n = 1'b1;
    step(2);
    chk_state("R7 re-requester wins", 1, 1'b1);

    // R5: owner parks when nobody requests
    breq_n = 4'b1111;
    step(4);
    chk_state("R5 parked", 1, 1'b1);

    // random traffic: agreement and round-robin order on every change
    d1 = breq_n; d2 = breq_n; prev = own[0];
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      chk_agree("R10 random agree");
      chk(busyv[0] === 1'b1, "R5 random busy", int'(busyv[0]), 1);
      if (own[0] !== prev) begin
        req = ~d2;
        exp_pick = -1;
        for (int k = NA; k >= 1; k--)
          if (req[(int'(prev) + k) % NA]) exp_pick = (int'(prev) + k) % NA;
        chk(int'(own[0]) == exp_pick, "R3 R4 random order", int'(own[0]), exp_pick);
      end
      prev = own[0];
      d2 = d1;
      d1 = NA'($urandom());
      breq_n = d1;
      ads_n = ($urandom() % 3) != 0;
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule